// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches the received byte stream while the controller sleeps. It looks for a wake pattern that may sit at any byte offset of a frame. The pattern is a run of at least six 0xFF bytes followed at once by sixteen back-to-back copies of the station's own 48-bit address. Each copy is sent most significant byte first, so the byte in bits 47:40 comes first. When a byte breaks the pattern, the search starts over from that byte.

A hit inside a frame is only a candidate. It is reported on the end-of-frame beat, and only if four conditions hold on that beat:
- the pattern completed somewhere in the frame;
- the wake enable bit is set;
- the power state is a low-power one (D1, D2 or D3);
- the receive filter's verdict for the frame (address match or broadcast) is positive.

A report raises a one-cycle detect pulse and sets a sticky event flag. The host clears the flag by writing one. A power-management request output follows the flag while PME signalling is enabled.

Top module: `mpkt_wake_detect`

## Requirements
- R1: A frame carrying six 0xFF bytes and then sixteen consecutive copies of `station_addr` raises `wake_pulse` for exactly one cycle and sets `wake_event`. The copies are sent high byte first (bits 47:40, then 39:32, down to 7:0). Both outputs rise in the cycle after the clock edge that takes the end-of-frame byte. A copy in reversed byte order is not recognised.
- R2: The pattern is found wherever it starts in the frame, including after unrelated leading bytes. It is also found when its last byte is the end-of-frame byte.
- R3: A sync run longer than six 0xFF bytes is accepted. A run of only five bytes is not. Only fifteen address copies is not.
- R4: A byte that breaks the pattern restarts the search. If the breaking byte is 0xFF, it counts as the first byte of a new sync run.
- R5: With `pwr_state` = 0 (D0), nothing is reported. Values 1, 2 and 3 (D1 to D3) allow a report.
- R6: With `wake_en` low, nothing is reported.
- R7: With `addr_pass` low on the end-of-frame beat, nothing is reported.
- R8: A report is committed only on the end-of-frame beat. No output changes earlier. Partial progress is discarded when a new frame starts, so a pattern split across two frames is not recognised.
- R9: `wake_event` stays set until a cycle with `evt_clr` = 1 clears it. A new detection in the same cycle as `evt_clr` wins, and the flag stays set.
- R10: `pme_req` is high exactly when `wake_event` is set and `pme_en` is high.
- R11: After reset, `wake_pulse`, `wake_event` and `pme_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_octet | input | 8 | Received byte |
| station_addr | input | 48 | Own station address, bits 47:40 sent first |
| wake_en | input | 1 | Pattern wake enable |
| pwr_state | input | 2 | Power state, 0 = D0 up to 3 = D3 |
| addr_pass | input | 1 | Receive filter verdict for this frame, read on the end-of-frame beat |
| pme_en | input | 1 | PME signalling enable |
| evt_clr | input | 1 | Write-one-to-clear for the event flag |
| wake_pulse | output | 1 | One-cycle detect pulse |
| wake_event | output | 1 | Sticky wake event flag |
| pme_req | output | 1 | Power management event request |

## Verification
Wrong internal state in this block shows only at the end of a frame.
- A sync run counter that saturates wrongly, or an address byte index that drifts, shows up as a missing or extra `wake_pulse` one cycle after the end-of-frame byte. That can be up to a full frame after the byte that went wrong.
- Stale progress carried over from the previous frame shows up only when the next frame ends.
- A fault in the sticky flag shows at `wake_event` and `pme_req` in the cycle after an `evt_clr` write or after a detection.

The frames used vary the offset, the sync run length, the copy count, the byte order and the break points. This puts each fault in a place where it changes the end-of-frame result.

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;

  localparam int unsigned MAX_ADDR_W = 64;

  typedef enum logic [1:0] {
    PWR_D0 = 2'd0,
    PWR_D1 = 2'd1,
    PWR_D2 = 2'd2,
    PWR_D3 = 2'd3
  } pwr_state_e;

  // Byte of the address at transmit position pos (position 0 = most significant byte).
  function automatic logic [7:0] addr_octet(input logic [MAX_ADDR_W-1:0] addr,
                                            input int unsigned n_octets,
                                            input int unsigned pos);
    int unsigned sh;
    sh = (n_octets - 1 - pos) * 8;
    return 8'(addr >> sh);
  endfunction

  function automatic logic is_sync_octet(input logic [7:0] b);
    return b == 8'hFF;
  endfunction

  // Increment that stops at lim.
  function automatic int unsigned sat_step(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // A wake may be reported only when enabled and outside the fully-on state.
  function automatic logic wake_allowed(input logic en, input logic [1:0] pwr);
    return en && (pwr != PWR_D0);
  endfunction

endpackage

// File: rtl/mpkt_sync_run.sv
module mpkt_sync_run #(
  parameter int unsigned SYNC_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic sof,
  input  logic in_addr,
  input  logic octet_ff,
  output logic sync_ready
);
  localparam int unsigned CW = $clog2(SYNC_LEN + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (beat) begin
      if (sof || in_addr) begin
        // a fresh run starts with this byte
        run_q <= octet_ff ? CW'(1) : '0;
      end else begin
        run_q <= octet_ff ? CW'(mpkt_pkg::sat_step(32'(run_q), SYNC_LEN)) : '0;
      end
    end
  end

  assign sync_ready = (run_q == CW'(SYNC_LEN));

endmodule

// File: rtl/mpkt_rep_match.sv
module mpkt_rep_match #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned REPS   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       beat,
  input  logic                       sof,
  input  logic [7:0]                 octet,
  input  logic [ADDR_W-1:0]          station_addr,
  input  logic                       sync_ready,
  output logic                       in_addr,
  output logic                       pattern_start,
  output logic                       pattern_done,
  output logic                       mismatch,
  output logic [$clog2(REPS)-1:0]    rep_cnt
);
  localparam int unsigned NB = ADDR_W / 8;
  localparam int unsigned IW = $clog2(NB);
  localparam int unsigned RW = $clog2(REPS);

  logic          in_q;
  logic [IW-1:0] idx_q;
  logic [RW-1:0] rep_q;

  logic          hunt;
  logic [IW-1:0] idx_cur;
  logic [7:0]    want;
  logic          hit;
  logic          last_oct;
  logic          last_rep;
  logic          advance;

  always_comb begin
    hunt     = sof || !in_q;
    idx_cur  = hunt ? '0 : idx_q;
    want     = mpkt_pkg::addr_octet(mpkt_pkg::MAX_ADDR_W'(station_addr), NB, 32'(idx_cur));
    hit      = (octet == want);
    last_oct = (idx_cur == IW'(NB - 1));
    last_rep = (rep_q == RW'(REPS - 1));
  end

  assign pattern_start = beat && hunt && !sof && sync_ready && hit;
  assign advance       = beat && !hunt && hit;
  assign mismatch      = beat && !hunt && !hit;
  assign pattern_done  = advance && last_oct && last_rep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= 1'b0;
      idx_q <= '0;
      rep_q <= '0;
    end else if (beat) begin
      if (pattern_start) begin
        in_q  <= 1'b1;
        idx_q <= IW'(1);
        rep_q <= '0;
      end else if (advance) begin
        if (last_oct) begin
          idx_q <= '0;
          if (last_rep) in_q <= 1'b0;
          else          rep_q <= rep_q + RW'(1);
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end else begin
        in_q <= 1'b0;
      end
    end
  end

  assign in_addr = in_q;
  assign rep_cnt = rep_q;

endmodule

// File: rtl/mpkt_event_commit.sv
module mpkt_event_commit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       sof,
  input  logic       eof,
  input  logic       pattern_done,
  input  logic       wake_en,
  input  logic [1:0] pwr_state,
  input  logic       addr_pass,
  input  logic       evt_clr,
  input  logic       pme_en,
  output logic       found,
  output logic       commit,
  output logic       wake_pulse,
  output logic       wake_event,
  output logic       pme_req
);
  logic found_q;
  logic seen;
  logic pulse_q;
  logic event_q;

  assign seen   = ((!sof && found_q) || pattern_done);
  assign commit = beat && eof && seen && addr_pass &&
                  mpkt_pkg::wake_allowed(wake_en, pwr_state);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      pulse_q <= 1'b0;
      event_q <= 1'b0;
    end else begin
      if (beat) found_q <= eof ? 1'b0 : seen;
      pulse_q <= commit;
      event_q <= commit || (event_q && !evt_clr);
    end
  end

  assign found      = found_q;
  assign wake_pulse = pulse_q;
  assign wake_event = event_q;
  assign pme_req    = event_q && pme_en;

endmodule

// File: rtl/mpkt_wake_detect.sv
module mpkt_wake_detect #(
  parameter int unsigned ADDR_W   = 48,
  parameter int unsigned SYNC_LEN = 6,
  parameter int unsigned REPS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_octet,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              wake_en,
  input  logic [1:0]        pwr_state,
  input  logic              addr_pass,
  input  logic              pme_en,
  input  logic              evt_clr,
  output logic              wake_pulse,
  output logic              wake_event,
  output logic              pme_req
);
  localparam int unsigned RW = $clog2(REPS);

  logic          beat;
  logic          sof_beat;
  logic          octet_ff;
  logic          sync_ready;
  logic          in_addr;
  logic          pattern_start;
  logic          pattern_done;
  logic          mismatch;
  logic [RW-1:0] rep_cnt;
  logic          found;
  logic          commit;

  assign beat     = rx_valid;
  assign sof_beat = rx_valid && rx_sof;
  assign octet_ff = mpkt_pkg::is_sync_octet(rx_octet);

  mpkt_sync_run #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .sof        (sof_beat),
    .in_addr    (in_addr),
    .octet_ff   (octet_ff),
    .sync_ready (sync_ready)
  );

  mpkt_rep_match #(.ADDR_W(ADDR_W), .REPS(REPS)) u_match (
    .clk           (clk),
    .rst_n         (rst_n),
    .beat          (beat),
    .sof           (sof_beat),
    .octet         (rx_octet),
    .station_addr  (station_addr),
    .sync_ready    (sync_ready),
    .in_addr       (in_addr),
    .pattern_start (pattern_start),
    .pattern_done  (pattern_done),
    .mismatch      (mismatch),
    .rep_cnt       (rep_cnt)
  );

  mpkt_event_commit u_event (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat         (beat),
    .sof          (sof_beat),
    .eof          (rx_eof),
    .pattern_done (pattern_done),
    .wake_en      (wake_en),
    .pwr_state    (pwr_state),
    .addr_pass    (addr_pass),
    .evt_clr      (evt_clr),
    .pme_en       (pme_en),
    .found        (found),
    .commit       (commit),
    .wake_pulse   (wake_pulse),
    .wake_event   (wake_event),
    .pme_req      (pme_req)
  );

endmodule

// File: rtl/mpkt_wake_sva.sv
module mpkt_wake_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_sof,
  input logic       rx_eof,
  input logic       wake_en,
  input logic [1:0] pwr_state,
  input logic       addr_pass,
  input logic       evt_clr,
  input logic       wake_pulse,
  input logic       wake_event,
  input logic       pme_req,
  input logic       pattern_start,
  input logic       pattern_done,
  input logic       in_addr,
  input logic       mismatch
);

  AST_PULSE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_eof) |=> !wake_pulse);  // R8

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);  // R1

  AST_NO_WAKE_D0: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eof && pwr_state == 2'd0) |=> !wake_pulse);  // R5

  AST_NO_WAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eof && !wake_en) |=> !wake_pulse);  // R6

  AST_NO_WAKE_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eof && !addr_pass) |=> !wake_pulse);  // R7

  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_event && !evt_clr) |=> wake_event);  // R9

  AST_EVENT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr |=> (wake_pulse || !wake_event));  // R9

  AST_EVENT_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_event) |-> wake_pulse);  // R9

  AST_PME_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    pme_req |-> wake_event);  // R10

  AST_DONE_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_done |-> in_addr);  // R1

  AST_BREAK_LEAVES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> !in_addr);  // R4

  AST_NO_START_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof) |-> !pattern_start);  // R8

endmodule

bind mpkt_wake_detect mpkt_wake_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_valid      (rx_valid),
  .rx_sof        (rx_sof),
  .rx_eof        (rx_eof),
  .wake_en       (wake_en),
  .pwr_state     (pwr_state),
  .addr_pass     (addr_pass),
  .evt_clr       (evt_clr),
  .wake_pulse    (wake_pulse),
  .wake_event    (wake_event),
  .pme_req       (pme_req),
  .pattern_start (pattern_start),
  .pattern_done  (pattern_done),
  .in_addr       (in_addr),
  .mismatch      (mismatch)
);

// File: tb/mpkt_wake_detect_test.sv
module mpkt_wake_detect_test;

  localparam logic [47:0] ADDR = 48'h112233445566;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_octet = 8'h00;
  logic       wake_en = 1'b1, addr_pass = 1'b1, pme_en = 1'b1, evt_clr = 1'b0;
  logic [1:0] pwr_state = 2'd3;
  logic       wake_pulse, wake_event, pme_req;

  always #10 clk = ~clk;

  mpkt_wake_detect uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_octet(rx_octet), .station_addr(ADDR), .wake_en(wake_en), .pwr_state(pwr_state),
    .addr_pass(addr_pass), .pme_en(pme_en), .evt_clr(evt_clr),
    .wake_pulse(wake_pulse), .wake_event(wake_event), .pme_req(pme_req)
  );

  typedef struct packed {
    logic [7:0] pre;
    logic [3:0] sync;
    logic [4:0] reps;
    logic [6:0] brk;
    logic [7:0] brk_val;
    logic [3:0] tail_sync;
    logic       rev;
    logic [1:0] pwr;
    logic       en;
    logic       pass;
    logic       exp;
  } vec_t;

  // pre, sync, reps, brk, brk_val, tail_sync, rev, pwr, en, pass, exp
  localparam vec_t VECS [13] = '{
    '{8'd0,  4'd6, 5'd16, 7'd0,  8'h00, 4'd0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1},  // R1 basic
    '{8'd20, 4'd6, 5'd16, 7'd0,  8'h00, 4'd0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1},  // R2 offset
    '{8'd0,  4'd5, 5'd16, 7'd0,  8'h00, 4'd0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0},  // R3 short sync
    '{8'd0,  4'd6, 5'd15, 7'd0,  8'h00, 4'd0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0},  // R3 15 copies
    '{8'd3,  4'd9, 5'd16, 7'd0,  8'h00, 4'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1},  // R3 long sync
    '{8'd0,  4'd6, 5'd16, 7'd0,  8'h00, 4'd0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0},  // R5 D0
    '{8'd0,  4'd6, 5'd16, 7'd0,  8'h00, 4'd0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0},  // R6 disabled
    '{8'd0,  4'd6, 5'd16, 7'd0,  8'h00, 4'd0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0},  // R7 filtered
    '{8'd0,  4'd6, 5'd16, 7'd30, 8'h00, 4'd0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0},  // R4 break only
    '{8'd0,  4'd6, 5'd16, 7'd30, 8'h00, 4'd6, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1},  // R4 restart
    '{8'd0,  4'd6, 5'd16, 7'd30, 8'hFF, 4'd5, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1},  // R4 FF counts
    '{8'd0,  4'd6, 5'd16, 7'd30, 8'h00, 4'd5, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0},  // R4 no credit
    '{8'd0,  4'd6, 5'd16, 7'd0,  8'h00, 4'd0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0}   // R1 reversed
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] fb [0:511];
  int flen = 0;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] own_byte(input int k, input bit rev);
    int p;
    p = rev ? (5 - k) : k;
    return ADDR[47 - 8*p -: 8];
  endfunction

  task automatic push(input logic [7:0] b);
    fb[flen] = b;
    flen++;
  endtask

  task automatic push_copies(input int n, input bit rev);
    for (int i = 0; i < n * 6; i++) push(own_byte(i % 6, rev));
  endtask

  task automatic build(input vec_t v);
    flen = 0;
    for (int i = 0; i < int'(v.pre); i++) push(8'((i * 13 + 5) & 8'h7F));
    for (int i = 0; i < int'(v.sync); i++) push(8'hFF);
    if (v.brk != 0) begin
      for (int i = 0; i < int'(v.brk) - 1; i++) push(own_byte(i % 6, v.rev));
      push(v.brk_val);
    end else begin
      push_copies(int'(v.reps), v.rev);
    end
    if (v.tail_sync != 0) begin
      for (int i = 0; i < int'(v.tail_sync); i++) push(8'hFF);
      push_copies(16, 1'b0);
    end
  endtask

  // Starts and ends at a falling edge; on return the end-of-frame byte has been taken.
  task automatic send_frame(input bit peek, input bit clr_on_eof, input string tag);
    for (int i = 0; i < flen; i++) begin
      if (peek && i == flen - 1) begin
        chk(wake_pulse, 1'b0, {tag, " no pulse before eof"});
        chk(wake_event, 1'b0, {tag, " no event before eof"});
      end
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == flen - 1);
      rx_octet = fb[i];
      evt_clr  = clr_on_eof && (i == flen - 1);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; evt_clr = 1'b0;
  endtask

  task automatic clear_event();
    evt_clr = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wake_pulse, 1'b0, "R11 reset pulse");
    chk(wake_event, 1'b0, "R11 reset event");
    chk(pme_req,    1'b0, "R11 reset pme");

    foreach (VECS[k]) begin
      pwr_state = VECS[k].pwr;
      wake_en   = VECS[k].en;
      addr_pass = VECS[k].pass;
      build(VECS[k]);
      send_frame(1'b0, 1'b0, "vec");
      chk(wake_pulse, VECS[k].exp, $sformatf("R1 vector %0d pulse", k));
      chk(wake_event, VECS[k].exp, $sformatf("R1 vector %0d event", k));
      chk(pme_req,    VECS[k].exp, $sformatf("R10 vector %0d pme", k));
      @(negedge clk);
      chk(wake_pulse, 1'b0, $sformatf("R1 vector %0d pulse width", k));
      clear_event();
    end
    pwr_state = 2'd3; wake_en = 1'b1; addr_pass = 1'b1;

    // R9 sticky flag and write-one-to-clear; R10 pme gating
    build(VECS[0]);
    send_frame(1'b0, 1'b0, "R9");
    repeat (5) @(negedge clk);
    chk(wake_event, 1'b1, "R9 event held");
    pme_en = 1'b0;
    #1;
    chk(pme_req, 1'b0, "R10 pme masked");
    pme_en = 1'b1;
    #1;
    chk(pme_req, 1'b1, "R10 pme unmasked");
    clear_event();
    chk(wake_event, 1'b0, "R9 event cleared");

    // R8 commit only on end-of-frame byte
    build(VECS[0]);
    for (int i = 0; i < 10; i++) push(8'h42);
    send_frame(1'b1, 1'b0, "R8");
    chk(wake_event, 1'b1, "R8 event at eof");
    clear_event();

    // R8 pattern split over two frames is not recognised
    flen = 0;
    for (int i = 0; i < 6; i++) push(8'hFF);
    push_copies(8, 1'b0);
    send_frame(1'b0, 1'b0, "R8a");
    chk(wake_pulse, 1'b0, "R8 first half");
    flen = 0;
    push_copies(8, 1'b0);
    send_frame(1'b0, 1'b0, "R8b");
    chk(wake_pulse, 1'b0, "R8 second half");
    chk(wake_event, 1'b0, "R8 split event");

    // R9 detection beats a same-cycle clear
    build(VECS[0]);
    send_frame(1'b0, 1'b1, "R9set");
    chk(wake_event, 1'b1, "R9 set wins over clear");
    clear_event();

    // R2 pattern followed by trailing bytes
    build(VECS[1]);
    for (int i = 0; i < 4; i++) push(8'h00);
    send_frame(1'b0, 1'b0, "R2");
    chk(wake_pulse, 1'b1, "R2 with trailer");
    clear_event();

    finish_run();
  end

endmodule